// File: doc/BRIEF.md
# Four-Channel Programmable Edge Delay

This block delays four one-bit signal streams by whole clock cycles. Every channel has a coarse delay code and a shape code. A global mode selects one of three ranges. It also selects whether the shape code is ignored, moves only the falling edge against the rising edge, or adds to the delay of both edges. The mode select has two pins. One is a plain bit. The other carries three levels (low, high and a third level) on a two-bit code. One combination of the two pins is rejected as invalid.

Each input edge is stamped with the cycle at which it must reappear and placed in a small per-channel queue. An output register takes the edge's level when a free-running cycle counter reaches that stamp. A fan-out control can OR the second channel's input into all four channels. In the split-edge modes a channel reports valid only after it has seen one full high pulse, meaning a rise and then a fall.

Top module: `edge_delay4`

## Requirements
- R1: Mode decode from {modeHi, modeLo}. modeHi 0 (low) gives mode 0 for modeLo=0 and mode 1 for modeLo=1. modeHi 1 (high) gives mode 2 and mode 3. modeHi 2 (third level) with modeLo=1 gives mode 5. modeHi 2 with modeLo=0 is invalid, and modeHi 3 is always invalid.
- R2: In modes 0 and 1 both edges are delayed by base + coarse, with base 4 in mode 0 and 8 in mode 1. The shape code has no effect.
- R3: In modes 2 and 3 the rising edge is delayed by base + coarse, with base 4 in mode 2 and 8 in mode 3. The falling edge is delayed by (rise delay + shape − 32), with a floor of 1.
- R4: In mode 5 both edges are delayed by 16 + coarse + shape.
- R5: An input edge present before clock edge k appears on dataOut at clock edge k + D, where D is the delay chosen for that edge by R2–R4 from the codes in force at edge k. The codes are 6-bit fields, and channel c uses bits [6c+5:6c].
- R6: An edge is never scheduled earlier than one cycle after the last edge still queued in its channel. A shortened fall therefore never overtakes or cancels the rise before it.
- R7: With fanAll low each channel uses its own input. With fanAll high each channel uses its own input ORed with dataIn[1].
- R8: Each channel holds up to 8 pending edges. An edge that arrives when the queue is full and no entry leaves in that cycle is dropped, and dropPulse for that channel is high for the following cycle.
- R9: While the mode is invalid, chanValid is 0, every queue is emptied, dataOut is forced low at the next clock edge and dropPulse stays low.
- R10: In modes 2 and 3, chanValid[c] is 0 until channel c has seen a rising edge followed by a falling edge since reset. In modes 0, 1 and 5, chanValid is all ones.
- R11: After reset dataOut and dropPulse are 0 and the rise/fall tracking of every channel is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 4 | Channel input streams |
| fanAll | input | 1 | OR dataIn[1] into every channel |
| modeLo | input | 1 | Two-level mode select |
| modeHi | input | 2 | Three-level mode select (0 low, 1 high, 2 third level) |
| coarseCode | input | 24 | Per-channel coarse delay, 6 bits each |
| shapeCode | input | 24 | Per-channel shape code, 6 bits each |
| dataOut | output | 4 | Delayed channel outputs |
| chanValid | output | 4 | Per-channel output valid |
| dropPulse | output | 4 | One-cycle pulse after a dropped edge |

## Verification
An input changed just after a falling clock edge is seen at the next rising edge. The matching output moves exactly D rising edges later, so latency tasks drive on falling edges and count falling edges until the output moves, taking one off the count. dropPulse is registered and is due one cycle after the rejected edge. chanValid is combinational on the mode pins, so checks on it wait a short settle time after the drive. The background model advances on every rising edge, and its comparison runs a quarter period later, well before the next falling-edge drive.

// File: rtl/edly_pkg.sv
package edly_pkg;
  parameter int NCH     = 4;
  parameter int CODE_W  = 6;
  parameter int Q_DEPTH = 8;
  parameter int TS_W    = 16;
  parameter int BASE_S  = 4;
  parameter int BASE_L  = 8;
  parameter int BASE_X  = 16;
  parameter int FAN_CH  = 1;

  localparam int CODE_MAX  = (1 << CODE_W) - 1;
  localparam int SHAPE_MID = 1 << (CODE_W - 1);
  localparam int DLY_W     = $clog2(BASE_X + 2 * CODE_MAX + 1);

  typedef enum logic [2:0] {
    MODE_SHORT   = 3'd0,
    MODE_LONG    = 3'd1,
    MODE_SPLIT_S = 3'd2,
    MODE_SPLIT_L = 3'd3,
    MODE_BAD     = 3'd4,
    MODE_SUM     = 3'd5
  } mode_e;

  typedef enum logic [1:0] {TRK_NONE, TRK_ROSE, TRK_DONE} trk_e;

  typedef struct packed {
    logic [DLY_W-1:0] riseDly;
    logic [DLY_W-1:0] fallDly;
  } laneDly_t;

  typedef struct packed {
    logic                 flush;
    laneDly_t [NCH-1:0]   lane;
  } ctrlStrobe_t;
endpackage

// File: rtl/edly_ctrl.sv
module edly_ctrl
  import edly_pkg::*;
(
  input  logic                  modeLo,
  input  logic [1:0]            modeHi,
  input  logic [NCH*CODE_W-1:0] coarseCode,
  input  logic [NCH*CODE_W-1:0] shapeCode,
  input  logic [NCH-1:0]        tracked,
  output ctrlStrobe_t           strobe,
  output logic [NCH-1:0]        chanValid
);
  mode_e mode;
  logic  splitMode;
  laneDly_t [NCH-1:0] dlyVec;

  always_comb begin
    case (modeHi)
      2'd0:    mode = modeLo ? MODE_LONG    : MODE_SHORT;
      2'd1:    mode = modeLo ? MODE_SPLIT_L : MODE_SPLIT_S;
      2'd2:    mode = modeLo ? MODE_SUM     : MODE_BAD;
      default: mode = MODE_BAD;
    endcase
  end

  assign splitMode = (mode == MODE_SPLIT_S) || (mode == MODE_SPLIT_L);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    int coarseI, shapeI, riseI, fallI;

    always_comb begin
      coarseI = int'(coarseCode[c*CODE_W +: CODE_W]);
      shapeI  = int'(shapeCode[c*CODE_W +: CODE_W]);
      case (mode)
        MODE_LONG: begin
          riseI = BASE_L + coarseI;
          fallI = riseI;
        end
        MODE_SPLIT_S, MODE_SPLIT_L: begin
          riseI = ((mode == MODE_SPLIT_L) ? BASE_L : BASE_S) + coarseI;
          fallI = riseI + shapeI - SHAPE_MID;
          if (fallI < 1) fallI = 1;
        end
        MODE_SUM: begin
          riseI = BASE_X + coarseI + shapeI;
          fallI = riseI;
        end
        default: begin
          riseI = BASE_S + coarseI;
          fallI = riseI;
        end
      endcase
    end

    assign dlyVec[c].riseDly = DLY_W'(riseI);
    assign dlyVec[c].fallDly = DLY_W'(fallI);
    assign chanValid[c] = (mode != MODE_BAD) && (!splitMode || tracked[c]);
  end

  always_comb begin
    strobe.flush = (mode == MODE_BAD);
    strobe.lane  = dlyVec;
  end
endmodule

// File: rtl/edly_lane.sv
module edly_lane
  import edly_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             effIn,
  input  logic [TS_W-1:0]  now,
  input  logic [DLY_W-1:0] riseDly,
  input  logic [DLY_W-1:0] fallDly,
  output logic             outLvl,
  output logic             tracked,
  output logic             dropPulse
);
  localparam int PTR_W = $clog2(Q_DEPTH);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  logic [TS_W-1:0]  dueQ [Q_DEPTH];
  logic             lvlQ [Q_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic [TS_W-1:0]  lastDue;
  logic             sampled;
  trk_e             trkSt;

  logic             riseEv, fallEv, anyEv;
  logic [DLY_W-1:0] stepDly;
  logic [TS_W-1:0]  rawDue, floorDue, gap, newDue;
  logic             headHit, full, accept;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(Q_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    riseEv   = effIn & ~sampled;
    fallEv   = ~effIn & sampled;
    anyEv    = riseEv | fallEv;
    stepDly  = riseEv ? riseDly : fallDly;
    rawDue   = now + TS_W'(stepDly);
    floorDue = lastDue + 1'b1;
    gap      = rawDue - floorDue;
    newDue   = ((count != '0) && gap[TS_W-1]) ? floorDue : rawDue;
    headHit  = (count != '0) && (dueQ[rdPtr] == now);
    full     = (count == CNT_W'(Q_DEPTH));
    accept   = anyEv && (!full || headHit);
  end

  always_ff @(posedge clk) begin
    if (accept && !flush) begin
      dueQ[wrPtr] <= newDue;
      lvlQ[wrPtr] <= riseEv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      lastDue   <= '0;
      outLvl    <= 1'b0;
      dropPulse <= 1'b0;
    end else if (flush) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      outLvl    <= 1'b0;
      dropPulse <= 1'b0;
    end else begin
      if (headHit) begin
        outLvl <= lvlQ[rdPtr];
        rdPtr  <= ptrNext(rdPtr);
      end
      if (accept) begin
        wrPtr   <= ptrNext(wrPtr);
        lastDue <= newDue;
      end
      count     <= count + CNT_W'(accept) - CNT_W'(headHit);
      dropPulse <= anyEv && !accept;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampled <= 1'b0;
      trkSt   <= TRK_NONE;
    end else begin
      sampled <= effIn;
      if (trkSt == TRK_NONE && riseEv)      trkSt <= TRK_ROSE;
      else if (trkSt == TRK_ROSE && fallEv) trkSt <= TRK_DONE;
    end
  end

  assign tracked = (trkSt == TRK_DONE);
endmodule

// File: rtl/edly_datapath.sv
module edly_datapath
  import edly_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] dataIn,
  input  logic           fanAll,
  input  ctrlStrobe_t    strobe,
  output logic [NCH-1:0] dataOut,
  output logic [NCH-1:0] tracked,
  output logic [NCH-1:0] dropPulse
);
  logic [TS_W-1:0] now;
  logic [NCH-1:0]  effIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) now <= '0;
    else       now <= now + 1'b1;
  end

  assign effIn = dataIn | {NCH{fanAll & dataIn[FAN_CH]}};

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    edly_lane lane_i (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (strobe.flush),
      .effIn    (effIn[c]),
      .now      (now),
      .riseDly  (strobe.lane[c].riseDly),
      .fallDly  (strobe.lane[c].fallDly),
      .outLvl   (dataOut[c]),
      .tracked  (tracked[c]),
      .dropPulse(dropPulse[c])
    );
  end
endmodule

// File: rtl/edge_delay4.sv
module edge_delay4
  import edly_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        dataIn,
  input  logic                  fanAll,
  input  logic                  modeLo,
  input  logic [1:0]            modeHi,
  input  logic [NCH*CODE_W-1:0] coarseCode,
  input  logic [NCH*CODE_W-1:0] shapeCode,
  output logic [NCH-1:0]        dataOut,
  output logic [NCH-1:0]        chanValid,
  output logic [NCH-1:0]        dropPulse
);
  ctrlStrobe_t    strobe;
  logic [NCH-1:0] tracked;

  edly_ctrl ctrl_i (
    .modeLo    (modeLo),
    .modeHi    (modeHi),
    .coarseCode(coarseCode),
    .shapeCode (shapeCode),
    .tracked   (tracked),
    .strobe    (strobe),
    .chanValid (chanValid)
  );

  edly_datapath path_i (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .fanAll   (fanAll),
    .strobe   (strobe),
    .dataOut  (dataOut),
    .tracked  (tracked),
    .dropPulse(dropPulse)
  );
endmodule

// File: rtl/edly_checker.sv
module edly_checker
  import edly_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           modeLo,
  input logic [1:0]     modeHi,
  input logic [NCH-1:0] dataOut,
  input logic [NCH-1:0] chanValid,
  input logic [NCH-1:0] dropPulse
);
  logic badNow, plainNow;

  assign badNow   = (modeHi == 2'd3) || (modeHi == 2'd2 && !modeLo);
  assign plainNow = (modeHi == 2'd0) || (modeHi == 2'd2 && modeLo);

  a_r9_invalid_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    badNow |-> chanValid == '0);

  a_r9_invalid_out_low: assert property (@(posedge clk) disable iff (!rstN)
    badNow |=> dataOut == '0);

  a_r9_invalid_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    badNow |=> dropPulse == '0);

  a_r10_plain_all_valid: assert property (@(posedge clk) disable iff (!rstN)
    plainNow |-> chanValid == {NCH{1'b1}});
endmodule

bind edge_delay4 edly_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .modeLo   (modeLo),
  .modeHi   (modeHi),
  .dataOut  (dataOut),
  .chanValid(chanValid),
  .dropPulse(dropPulse)
);

// File: tb/edge_delay4_tb.sv
module edge_delay4_tb_top;
  localparam int CLK_PER = 10;
  localparam int NC = 4;
  localparam int CW = 6;
  localparam int QD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0] dataIn = '0;
  logic fanAll = 1'b0;
  logic modeLo = 1'b0;
  logic [1:0] modeHi = 2'd0;
  logic [NC*CW-1:0] coarseCode = '0;
  logic [NC*CW-1:0] shapeCode = '0;
  logic [NC-1:0] dataOut, chanValid, dropPulse;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmpOn = 0;
  string curReq = "R11";
  bit [31:0] rng = 32'h1234_5678;

  // reference model state
  int mDue [NC][QD];
  bit mLvl [NC][QD];
  int mHead [NC], mCnt [NC], mLast [NC], mTrk [NC];
  bit mSamp [NC], mOut [NC], mDrop [NC];
  int mNow = 0;

  always #(CLK_PER/2) clk = ~clk;

  edge_delay4 dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .fanAll(fanAll),
    .modeLo(modeLo), .modeHi(modeHi), .coarseCode(coarseCode),
    .shapeCode(shapeCode), .dataOut(dataOut), .chanValid(chanValid),
    .dropPulse(dropPulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_mode();
    case (modeHi)
      2'd0: return modeLo ? 1 : 0;
      2'd1: return modeLo ? 3 : 2;
      2'd2: return modeLo ? 5 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic int edge_delay(input int c, input bit isRise);
    int md, co, sh, r, f;
    md = model_mode();
    co = int'(coarseCode[c*CW +: CW]);
    sh = int'(shapeCode[c*CW +: CW]);
    case (md)
      1: r = 8 + co;
      2, 3: r = ((md == 3) ? 8 : 4) + co;
      5: r = 16 + co + sh;
      default: r = 4 + co;
    endcase
    f = r;
    if (md == 2 || md == 3) begin
      f = r + sh - 32;
      if (f < 1) f = 1;
    end
    return isRise ? r : f;
  endfunction

  function automatic bit model_valid(input int c);
    int md;
    md = model_mode();
    if (md < 0) return 1'b0;
    if (md == 2 || md == 3) return mTrk[c] == 2;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    int md, due, cb;
    bit eff, rs, fl, hit;
    if (rstN) begin
      md = model_mode();
      for (int c = 0; c < NC; c++) begin
        eff = dataIn[c] | (fanAll & dataIn[1]);
        rs = eff & !mSamp[c];
        fl = !eff & mSamp[c];
        if (md < 0) begin
          mCnt[c] = 0; mHead[c] = 0; mOut[c] = 0; mDrop[c] = 0;
        end else begin
          cb = mCnt[c];
          hit = (cb > 0) && (mDue[c][mHead[c]] == mNow);
          due = mNow + edge_delay(c, rs);
          if (cb > 0 && due < mLast[c] + 1) due = mLast[c] + 1;
          if (hit) begin
            mOut[c] = mLvl[c][mHead[c]];
            mHead[c] = (mHead[c] + 1) % QD;
            mCnt[c]--;
          end
          mDrop[c] = 0;
          if (rs || fl) begin
            if (mCnt[c] < QD) begin
              mDue[c][(mHead[c] + mCnt[c]) % QD] = due;
              mLvl[c][(mHead[c] + mCnt[c]) % QD] = rs;
              mLast[c] = due;
              mCnt[c]++;
            end else mDrop[c] = 1;
          end
        end
        if (mTrk[c] == 0 && rs) mTrk[c] = 1;
        else if (mTrk[c] == 1 && fl) mTrk[c] = 2;
        mSamp[c] = eff;
      end
      mNow++;
    end
  end

  always begin
    @(posedge clk);
    #(CLK_PER/4);
    if (cmpOn) begin
      for (int c = 0; c < NC; c++) begin
        check(dataOut[c] == mOut[c], curReq, $sformatf("model dataOut[%0d]", c),
              int'(dataOut[c]), int'(mOut[c]));
        check(dropPulse[c] == mDrop[c], curReq, $sformatf("model dropPulse[%0d]", c),
              int'(dropPulse[c]), int'(mDrop[c]));
        check(chanValid[c] == model_valid(c), curReq, $sformatf("model chanValid[%0d]", c),
              int'(chanValid[c]), int'(model_valid(c)));
      end
    end
  end

  task automatic set_codes(input int c, input int co, input int sh);
    coarseCode[c*CW +: CW] = CW'(co);
    shapeCode[c*CW +: CW]  = CW'(sh);
  endtask

  task automatic do_reset(input logic [1:0] hi, input logic lo);
    @(negedge clk);
    rstN = 1'b0;
    dataIn = '0; fanAll = 1'b0; modeHi = hi; modeLo = lo;
    for (int c = 0; c < NC; c++) begin
      mHead[c] = 0; mCnt[c] = 0; mLast[c] = 0; mTrk[c] = 0;
      mSamp[c] = 0; mOut[c] = 0; mDrop[c] = 0;
    end
    mNow = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drives channel c to lvl and returns the measured delay in cycles
  task automatic edge_latency(input int c, input bit lvl, output int d);
    int n;
    @(negedge clk);
    dataIn[c] = lvl;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (dataOut[c] != lvl && n < 400);
    d = n - 1;
  endtask

  task automatic t_reset();
    curReq = "R11";
    do_reset(2'd1, 1'b0);
    @(negedge clk); #1;
    check(dataOut == '0, "R11", "dataOut after reset", int'(dataOut), 0);
    check(dropPulse == '0, "R11", "dropPulse after reset", int'(dropPulse), 0);
    check(chanValid == '0, "R11", "tracking cleared (mode 2 valid)", int'(chanValid), 0);
    modeHi = 2'd0; #1;
    check(chanValid == 4'hF, "R10", "mode 0 all valid", int'(chanValid), 15);
  endtask

  task automatic t_plain();
    int d;
    curReq = "R2";
    do_reset(2'd0, 1'b0);
    set_codes(0, 3, 50);
    edge_latency(0, 1'b1, d);
    check(d == 7, "R2", "mode 0 rise delay, shape ignored", d, 7);
    edge_latency(0, 1'b0, d);
    check(d == 7, "R5", "mode 0 fall delay", d, 7);
    modeLo = 1'b1;
    set_codes(2, 10, 0);
    edge_latency(2, 1'b1, d);
    check(d == 18, "R1", "mode 1 rise delay", d, 18);
    set_codes(2, 10, 63);
    edge_latency(2, 1'b0, d);
    check(d == 18, "R2", "mode 1 fall delay, shape ignored", d, 18);
  endtask

  task automatic t_split();
    int d, w;
    curReq = "R3";
    do_reset(2'd1, 1'b0);
    set_codes(0, 5, 40);
    #1;
    check(chanValid[0] == 1'b0, "R10", "split valid before pulse", int'(chanValid[0]), 0);
    edge_latency(0, 1'b1, d);
    check(d == 9, "R3", "mode 2 rise delay", d, 9);
    check(chanValid[0] == 1'b0, "R10", "split valid after rise only", int'(chanValid[0]), 0);
    edge_latency(0, 1'b0, d);
    check(d == 17, "R3", "mode 2 fall delay", d, 17);
    check(chanValid == 4'b0001, "R10", "split valid after full pulse", int'(chanValid), 1);
    // fall shortened below rise: ordering floor
    curReq = "R6";
    set_codes(0, 5, 0);
    @(negedge clk); dataIn[0] = 1'b1;
    @(negedge clk); dataIn[0] = 1'b0;
    d = 0;
    while (dataOut[0] == 1'b0 && d < 100) begin @(negedge clk); d++; end
    w = 0;
    while (dataOut[0] == 1'b1 && w < 100) begin @(negedge clk); w++; end
    check(w == 1, "R6", "clamped fall one cycle after rise", w, 1);
    modeLo = 1'b1;
    set_codes(1, 2, 63);
    edge_latency(1, 1'b1, d);
    check(d == 10, "R3", "mode 3 rise delay", d, 10);
    edge_latency(1, 1'b0, d);
    check(d == 41, "R3", "mode 3 fall delay", d, 41);
  endtask

  task automatic t_sum();
    int d;
    curReq = "R4";
    do_reset(2'd2, 1'b1);
    set_codes(3, 5, 7);
    edge_latency(3, 1'b1, d);
    check(d == 28, "R4", "mode 5 rise delay", d, 28);
    edge_latency(3, 1'b0, d);
    check(d == 28, "R4", "mode 5 fall delay", d, 28);
  endtask

  task automatic t_fan();
    int d;
    curReq = "R7";
    do_reset(2'd0, 1'b0);
    for (int c = 0; c < NC; c++) set_codes(c, 2, 0);
    fanAll = 1'b1;
    edge_latency(1, 1'b1, d);
    check(dataOut == 4'hF, "R7", "fan-out from channel 1", int'(dataOut), 15);
    edge_latency(1, 1'b0, d);
    fanAll = 1'b0;
    edge_latency(1, 1'b1, d);
    check(dataOut == 4'b0010, "R7", "no fan-out when low", int'(dataOut), 2);
    edge_latency(1, 1'b0, d);
    fanAll = 1'b1;
    edge_latency(2, 1'b1, d);
    check(dataOut == 4'b0100, "R7", "channel 2 not fanned", int'(dataOut), 4);
    edge_latency(2, 1'b0, d);
  endtask

  task automatic t_overflow();
    int drops;
    curReq = "R8";
    do_reset(2'd2, 1'b1);
    set_codes(0, 63, 63);
    drops = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      dataIn[0] = ~dataIn[0];
      if (dropPulse[0]) drops++;
    end
    repeat (160) begin
      @(negedge clk);
      if (dropPulse[0]) drops++;
    end
    check(drops == 4, "R8", "dropped edges with full queue", drops, 4);
  endtask

  task automatic t_invalid();
    int hits;
    curReq = "R9";
    do_reset(2'd0, 1'b0);
    set_codes(0, 16, 0);
    @(negedge clk); dataIn[0] = 1'b1;
    repeat (3) @(negedge clk);
    modeHi = 2'd2; modeLo = 1'b0;
    #1;
    check(chanValid == '0, "R9", "valid low in invalid mode", int'(chanValid), 0);
    hits = 0;
    repeat (30) begin
      @(negedge clk);
      if (dataOut != '0) hits++;
    end
    check(hits == 0, "R9", "output held low, queued edge discarded", hits, 0);
    modeHi = 2'd3; modeLo = 1'b1;
    #1;
    check(chanValid == '0, "R1", "code 3 invalid", int'(chanValid), 0);
    @(negedge clk);
    modeHi = 2'd0; modeLo = 1'b0;
    repeat (40) @(negedge clk);
    check(dataOut[0] == 1'b0, "R9", "no stale edge after leaving invalid", int'(dataOut[0]), 0);
  endtask

  task automatic t_stress();
    curReq = "R6";
    do_reset(2'd0, 1'b0);
    for (int blk = 0; blk < 16; blk++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      @(negedge clk);
      modeHi = rng[1:0]; modeLo = rng[2]; fanAll = rng[3];
      for (int c = 0; c < NC; c++) set_codes(c, int'(rng[c*6 +: 6]) & 31, int'(rng[(c*6+4) % 26 +: 6]));
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        if (rng[7:5] == 3'd0) dataIn = rng[3:0];
      end
    end
  endtask

  initial begin
    cmpOn = 1'b1;
    t_reset();
    t_plain();
    t_split();
    t_sum();
    t_fan();
    t_overflow();
    t_invalid();
    t_stress();
    cmpOn = 1'b0;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule